// File: doc/BRIEF.md
# Multi-lane serial flash read sequencer

This block fetches one byte from a serial NOR flash per command. It supports five lane formats: 1-1-1, 1-1-2, 1-2-2, 1-1-4 and 1-4-4. The opcode always goes out on a single line. The address is 3 or 4 bytes wide and goes out on 1, 2 or 4 lines. Next comes a run of dummy clocks, whose length depends on the lane format. Finally, one data byte is sampled on 1, 2 or 4 lines. Software writes a bus-configuration value, a fast-read flag, two opcode slots (one for dual reads, one for quad reads) and four address byte registers. It then pulses start and waits for the busy flag to drop. The byte that was read then sits in the read-data output.

The serial clock runs at half the system clock. Each serial clock takes two system cycles: a low half and a high half. Outputs change only after a high half ends. Input lines are sampled at the end of each high half. Chip select is low for the whole command. The sequencer captures the decoded command when start is accepted, so the inputs may change during a transfer without effect.

Top module: `flash_rd_seq`

## Requirements
- R1: After reset, busy is 0, cs_n is 1, sclk is 0, io_oe is 0 and rd_data is 0.
- R2: Opcode choice:
  - A single-lane read sends 0x03 when fast_rd is 0 and 0x0B when fast_rd is 1.
  - A dual-data read sends op_dual.
  - A quad-data read sends op_quad.
  - The opcode takes 8 clocks on io[0], most significant bit first, with io_oe = 4'b0001.
- R3: bus_cfg field meanings:
  - bit 4 selects a 4-byte address.
  - bit 2 selects quad data, and bit 0 selects dual data. Quad wins when both are set.
  - bit 3 selects quad address and counts only with quad data.
  - bit 1 selects dual address and counts only with dual data.
  - In every other case the address uses one lane.
- R4: Address sending:
  - The address bytes are, from least significant, addr_b0, addr_b1, addr_b2, then addr_b3.
  - addr_b3 is sent only when 4-byte addressing is selected.
  - The address goes most significant first, with the highest-numbered active line carrying the more significant bit.
  - It takes 24/L or 32/L clocks on L lanes.
- R5: Dummy clock count:
  - Dual or quad data: 8 clocks for a 1-lane address, 4 for a 2-lane address, 6 for a 4-lane address.
  - Single-lane read: 8 clocks when fast_rd is 1, 0 when it is 0.
- R6: io_oe is 4'b0001 in the opcode phase. In the address phase it enables the address lanes (0001, 0011 or 1111). In the dummy and data phases it is 0.
- R7: Data is sampled MSB first on each clock's high half:
  - on io[1] for one lane,
  - on io[1:0] for two lanes (io[1] more significant),
  - on io[3:0] for four lanes.
  The full byte appears on rd_data in the cycle busy falls and holds until the next command ends.
- R8: A start accepted while idle raises busy on the next cycle. Busy stays high for exactly 2·N cycles, where N = 8 + address clocks + dummy clocks + 8/data lanes. sclk is low while idle and alternates low/high during a command.
- R9: A start pulse while busy is ignored. Changes to bus_cfg, fast_rd, the opcode slots or the address bytes during a command do not affect it.
- R10: cs_n is low exactly while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cfg | input | 5 | Lane/address-size configuration (R3 field layout) |
| fast_rd | input | 1 | Selects 0x0B with 8 dummy clocks for single-lane reads |
| op_dual | input | 8 | Opcode used for dual-data reads |
| op_quad | input | 8 | Opcode used for quad-data reads |
| addr_b0 | input | 8 | Address byte 0 (least significant) |
| addr_b1 | input | 8 | Address byte 1 |
| addr_b2 | input | 8 | Address byte 2 |
| addr_b3 | input | 8 | Address byte 3, used only with 4-byte addressing |
| start | input | 1 | Starts a read when idle |
| busy | output | 1 | High while a read is in progress; falls when it ends |
| rd_data | output | 8 | Byte returned by the last read |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Values driven on the IO lines |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Values sampled from the IO lines |

## Verification
The assertions check, on every cycle:
- io_oe is one of the four legal masks;
- io_oe is 0001 during the opcode and 0 through the dummy and data phases;
- sclk stays low while deselected and follows every low half with a high half;
- rd_data changes only when busy falls;
- the captured command holds steady for the whole transfer.

Only the bench's scenarios can show the lane decode, the opcode and address actually sent, the dummy length and the assembled byte. The bench sweeps all 32 bus_cfg values with both fast_rd settings against a flash model that records what it receives and returns a known byte. It computes each expected opcode, address, lane mask and busy length arithmetically.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam int OP_W    = 8;
  localparam int ADDR_W  = 32;
  localparam int TX_W    = OP_W + ADDR_W;
  localparam int LANES   = 4;
  localparam int CFG_W   = 5;
  localparam int CNT_W   = 6;
  localparam int DATA_W  = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA
  } phase_t;

  typedef struct packed {
    logic              four_b;
    logic [2:0]        al;      // address lanes: 1, 2 or 4
    logic [2:0]        dl;      // data lanes: 1, 2 or 4
    logic [3:0]        dummy;   // dummy clocks
    logic [OP_W-1:0]   opcode;
    logic [ADDR_W-1:0] addr;
  } rd_cmd_t;

  function automatic logic [2:0] data_lanes(input logic [CFG_W-1:0] c);
    return c[2] ? 3'd4 : (c[0] ? 3'd2 : 3'd1);
  endfunction

  function automatic logic [2:0] addr_lanes(input logic [CFG_W-1:0] c);
    if (c[2])      return c[3] ? 3'd4 : 3'd1;
    else if (c[0]) return c[1] ? 3'd2 : 3'd1;
    else           return 3'd1;
  endfunction

  function automatic logic [3:0] dummy_clks(input logic [2:0] al, input logic [2:0] dl,
                                            input logic fast);
    if (dl == 3'd1) return fast ? 4'd8 : 4'd0;
    case (al)
      3'd2:    return 4'd4;
      3'd4:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] addr_clks(input logic four_b, input logic [2:0] al);
    case (al)
      3'd2:    return four_b ? CNT_W'(16) : CNT_W'(12);
      3'd4:    return four_b ? CNT_W'(8)  : CNT_W'(6);
      default: return four_b ? CNT_W'(32) : CNT_W'(24);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] data_clks(input logic [2:0] dl);
    case (dl)
      3'd2:    return CNT_W'(4);
      3'd4:    return CNT_W'(2);
      default: return CNT_W'(8);
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] l);
    case (l)
      3'd2:    return 4'b0011;
      3'd4:    return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction
endpackage

// File: rtl/frs_decode.sv
module frs_decode
  import frs_pkg::*;
#(
  parameter logic [OP_W-1:0] SLOW_OPC = 8'h03,
  parameter logic [OP_W-1:0] FAST_OPC = 8'h0B
) (
  input  logic [CFG_W-1:0] bus_cfg,
  input  logic             fast_rd,
  input  logic [OP_W-1:0]  op_dual,
  input  logic [OP_W-1:0]  op_quad,
  input  logic [7:0]       addr_b0,
  input  logic [7:0]       addr_b1,
  input  logic [7:0]       addr_b2,
  input  logic [7:0]       addr_b3,
  output rd_cmd_t          cmd
);
  logic [2:0] al, dl;

  always_comb begin
    al = addr_lanes(bus_cfg);
    dl = data_lanes(bus_cfg);
    cmd.four_b = bus_cfg[4];
    cmd.al     = al;
    cmd.dl     = dl;
    cmd.dummy  = dummy_clks(al, dl, fast_rd);
    if (dl == 3'd4)      cmd.opcode = op_quad;
    else if (dl == 3'd2) cmd.opcode = op_dual;
    else                 cmd.opcode = fast_rd ? FAST_OPC : SLOW_OPC;
    cmd.addr = {(bus_cfg[4] ? addr_b3 : 8'h00), addr_b2, addr_b1, addr_b0};
  end
endmodule

// File: rtl/frs_engine.sv
module frs_engine
  import frs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  rd_cmd_t           cmd_d,
  input  logic [LANES-1:0]  io_in,
  output rd_cmd_t           cmd_q,
  output phase_t            phase,
  output logic              half,
  output logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  io_out,
  output logic [LANES-1:0]  io_oe
);
  logic [CNT_W-1:0]  left;
  logic [TX_W-1:0]   tx;
  logic [DATA_W-1:0] rx, rx_next;
  logic              last;

  assign last = (left == '0);

  always_comb begin
    case (cmd_q.dl)
      3'd2:    rx_next = {rx[DATA_W-3:0], io_in[1:0]};
      3'd4:    rx_next = {rx[DATA_W-5:0], io_in};
      default: rx_next = {rx[DATA_W-2:0], io_in[1]};
    endcase
  end

  always_comb begin
    io_out = '0;
    io_oe  = '0;
    if (phase == PH_CMD) begin
      io_out = {3'b000, tx[TX_W-1]};
      io_oe  = 4'b0001;
    end else if (phase == PH_ADDR) begin
      io_oe = lane_mask(cmd_q.al);
      case (cmd_q.al)
        3'd2:    io_out = {2'b00, tx[TX_W-1 -: 2]};
        3'd4:    io_out = tx[TX_W-1 -: 4];
        default: io_out = {3'b000, tx[TX_W-1]};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      half    <= 1'b0;
      left    <= '0;
      tx      <= '0;
      rx      <= '0;
      rd_data <= '0;
      cmd_q   <= '0;
    end else if (phase == PH_IDLE) begin
      half <= 1'b0;
      if (start) begin
        cmd_q <= cmd_d;
        tx    <= {cmd_d.opcode, cmd_d.four_b ? cmd_d.addr : {cmd_d.addr[23:0], 8'h00}};
        rx    <= '0;
        left  <= CNT_W'(OP_W - 1);
        phase <= PH_CMD;
      end
    end else if (!half) begin
      half <= 1'b1;
    end else begin
      half <= 1'b0;
      left <= left - CNT_W'(1);
      case (phase)
        PH_CMD: begin
          tx <= tx << 1;
          if (last) begin
            phase <= PH_ADDR;
            left  <= addr_clks(cmd_q.four_b, cmd_q.al) - CNT_W'(1);
          end
        end
        PH_ADDR: begin
          tx <= tx << cmd_q.al;
          if (last) begin
            if (cmd_q.dummy != 4'd0) begin
              phase <= PH_DUMMY;
              left  <= CNT_W'(cmd_q.dummy) - CNT_W'(1);
            end else begin
              phase <= PH_DATA;
              left  <= data_clks(cmd_q.dl) - CNT_W'(1);
            end
          end
        end
        PH_DUMMY: begin
          if (last) begin
            phase <= PH_DATA;
            left  <= data_clks(cmd_q.dl) - CNT_W'(1);
          end
        end
        PH_DATA: begin
          rx <= rx_next;
          if (last) begin
            phase   <= PH_IDLE;
            rd_data <= rx_next;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
  import frs_pkg::*;
#(
  parameter logic [7:0] SLOW_OPC = 8'h03,
  parameter logic [7:0] FAST_OPC = 8'h0B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_cfg,
  input  logic        fast_rd,
  input  logic [7:0]  op_dual,
  input  logic [7:0]  op_quad,
  input  logic [7:0]  addr_b0,
  input  logic [7:0]  addr_b1,
  input  logic [7:0]  addr_b2,
  input  logic [7:0]  addr_b3,
  input  logic        start,
  output logic        busy,
  output logic [7:0]  rd_data,
  output logic        sclk,
  output logic        cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);
  rd_cmd_t cmd_d, cfg_q;
  phase_t  phase;
  logic    half;
  logic    cmd_phase, rx_phase;

  frs_decode #(.SLOW_OPC(SLOW_OPC), .FAST_OPC(FAST_OPC)) dec_i (
    .bus_cfg(bus_cfg), .fast_rd(fast_rd), .op_dual(op_dual), .op_quad(op_quad),
    .addr_b0(addr_b0), .addr_b1(addr_b1), .addr_b2(addr_b2), .addr_b3(addr_b3),
    .cmd(cmd_d)
  );

  frs_engine eng_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_d(cmd_d), .io_in(io_in),
    .cmd_q(cfg_q), .phase(phase), .half(half), .rd_data(rd_data),
    .io_out(io_out), .io_oe(io_oe)
  );

  assign busy      = (phase != PH_IDLE);
  assign cs_n      = (phase == PH_IDLE);
  assign sclk      = half;
  assign cmd_phase = (phase == PH_CMD);
  assign rx_phase  = (phase == PH_DUMMY) || (phase == PH_DATA);
endmodule

// File: rtl/frs_chk.sv
module frs_chk
  import frs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic [7:0] rd_data,
  input logic       cmd_phase,
  input logic       rx_phase,
  input rd_cmd_t    cfg_q
);
  AST_OE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111)); // R6
  AST_OE_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_phase |-> (io_oe == 4'b0000)); // R6
  AST_OPC_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_phase |-> (io_oe == 4'b0001)); // R2
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R8
  AST_SCLK_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !sclk) |=> sclk); // R8
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(rd_data)); // R7
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> $stable(cfg_q)); // R9
endmodule

bind flash_rd_seq frs_chk chk_i (.*);

// File: tb/flash_rd_seq_tb.sv
`timescale 1ns/1ps
module flash_rd_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_cfg = '0;
  logic       fast_rd = 1'b0;
  logic [7:0] op_dual = '0, op_quad = '0;
  logic [7:0] addr_b0 = '0, addr_b1 = '0, addr_b2 = '0, addr_b3 = '0;
  logic       start = 1'b0;
  logic       busy, sclk, cs_n;
  logic [7:0] rd_data;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  flash_rd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cfg(bus_cfg), .fast_rd(fast_rd),
    .op_dual(op_dual), .op_quad(op_quad), .addr_b0(addr_b0), .addr_b1(addr_b1),
    .addr_b2(addr_b2), .addr_b3(addr_b3), .start(start), .busy(busy),
    .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in)
  );

  // expected transfer shape, set per command
  int         e_al = 1, e_dl = 1, e_aclk = 24, e_dum = 0;
  logic [7:0] e_byte = '0;
  int         rises = 0, falls = 0;
  logic [7:0]  op_cap;
  logic [31:0] ad_cap;
  logic        oe_bad;

  // flash model: records what arrives on rising edges
  always @(posedge sclk) begin
    logic [3:0] m;
    m = (e_al == 4) ? 4'hF : (e_al == 2) ? 4'h3 : 4'h1;
    if (rises < 8) begin
      op_cap = {op_cap[6:0], io_out[0]};
      if (io_oe !== 4'b0001) oe_bad = 1'b1;
    end else if (rises < 8 + e_aclk) begin
      ad_cap = (ad_cap << e_al) | 32'(io_out & m);
      if (io_oe !== m) oe_bad = 1'b1;
    end else if (io_oe !== 4'b0000) oe_bad = 1'b1;
    rises = rises + 1;
  end

  always @(negedge sclk) falls = falls + 1;

  // flash model: drives data, counted in completed clocks
  always @* begin
    int d;
    d = falls - (8 + e_aclk + e_dum);
    io_in = 4'b1010;
    if (d >= 0 && d < 8 / e_dl) begin
      if (e_dl == 4)      io_in = e_byte[7 - 4*d -: 4];
      else if (e_dl == 2) io_in = {2'b10, e_byte[7 - 2*d -: 2]};
      else                io_in = {2'b10, e_byte[7 - d], 1'b1};
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [4:0] cfg, input bit fast, input logic [7:0] dbyte,
                         input bit poke);
    int         cyc;
    bit         cs_bad;
    logic [7:0] e_op;
    logic [31:0] e_addr;
    int          n_clk;
    @(negedge clk);
    bus_cfg = cfg; fast_rd = fast;
    op_dual = 8'h3B ^ {3'b000, cfg}; op_quad = 8'hEB ^ {cfg, 3'b000};
    addr_b0 = 8'h11 + 8'(cfg) * 8'd7; addr_b1 = 8'hA2 ^ {cfg, 3'b101};
    addr_b2 = 8'h5C + 8'(cfg);        addr_b3 = 8'hC9 ^ {3'b010, cfg};
    // bench's own decode of the configuration (R3)
    e_dl   = cfg[2] ? 4 : (cfg[0] ? 2 : 1);
    e_al   = (e_dl == 4) ? (cfg[3] ? 4 : 1) : (e_dl == 2) ? (cfg[1] ? 2 : 1) : 1;
    e_aclk = (cfg[4] ? 32 : 24) / e_al;
    if (e_dl == 1) e_dum = fast ? 8 : 0;
    else           e_dum = (e_al == 1) ? 8 : (e_al == 2) ? 4 : 6;
    e_op   = (e_dl == 4) ? op_quad : (e_dl == 2) ? op_dual : (fast ? 8'h0B : 8'h03);
    e_addr = cfg[4] ? {addr_b3, addr_b2, addr_b1, addr_b0} : {8'h00, addr_b2, addr_b1, addr_b0};
    e_byte = dbyte;
    n_clk  = 8 + e_aclk + e_dum + 8 / e_dl;
    rises = 0; falls = 0; op_cap = '0; ad_cap = '0; oe_bad = 1'b0; cs_bad = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy === 1'b1 && cyc < 400) begin
      if (cs_n !== 1'b0) cs_bad = 1'b1;
      cyc++;
      if (poke && cyc == 9) begin
        // R9: disturb every input and pulse start mid-command
        bus_cfg = ~cfg; fast_rd = ~fast; op_dual = 8'h00; op_quad = 8'hFF;
        addr_b0 = 8'h00; addr_b1 = 8'hFF; addr_b2 = 8'h00; addr_b3 = 8'hFF;
        start = 1'b1;
      end
      if (poke && cyc == 10) start = 1'b0;
      @(negedge clk);
    end
    if (cs_n !== 1'b1) cs_bad = 1'b1;
    check(e_op == op_cap, "R2 R3", "opcode sent", 32'(op_cap), 32'(e_op));
    check(e_addr == ad_cap, "R4", "address sent", ad_cap, e_addr);
    check(!oe_bad, "R6", "lane enables per phase", 32'(oe_bad), 32'd0);
    check(rd_data === dbyte, "R7", "byte read", 32'(rd_data), 32'(dbyte));
    check(cyc == 2 * n_clk, "R5 R8", "busy length", 32'(cyc), 32'(2 * n_clk));
    check(!cs_bad, "R10", "cs_n tracks busy", 32'(cs_bad), 32'd0);
    if (poke) begin
      // no second command was started by the ignored pulse
      repeat (3) @(negedge clk);
      check(busy === 1'b0, "R9", "start while busy ignored", 32'(busy), 32'd0);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && cs_n === 1'b1 && sclk === 1'b0 && io_oe === 4'b0000,
          "R1", "idle outputs in reset", {busy, cs_n, sclk, io_oe}, 32'h20);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data === 8'h00, "R1", "rd_data after reset", 32'(rd_data), 32'h0);
    for (int c = 0; c < 32; c++) begin
      for (int f = 0; f < 2; f++) begin
        run_one(5'(c), f[0], 8'h96 ^ 8'(c * 13 + f * 77), 1'b0);
      end
    end
    run_one(5'b10110, 1'b0, 8'h5A, 1'b1);
    run_one(5'b00011, 1'b1, 8'hC3, 1'b1);
    run_one(5'b00000, 1'b0, 8'h00, 1'b0);
    run_one(5'b11100, 1'b1, 8'hFF, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule